// File: doc/BRIEF.md
# Strobe/Acknowledge Handshake Sequencer

This block sits between a bus master and a local peripheral. The bus master requests a transfer by raising either a read strobe or a write strobe. The peripheral answers a local strobe with a local acknowledge. The block turns each bus request into a fixed sequence on three outputs: a local strobe toward the device, an enable for the data transceiver, and an acknowledge back to the bus. Read and write cycles are alternatives. The cycle type is set by whichever strobe the block sees while it is idle.

A read lowers the transceiver enable before it takes down the local strobe and the bus acknowledge. Those two then fall together, so the device's release of its acknowledge overlaps the bus acknowledge returning to zero. A write drives the transceiver before it strobes the device, and drops the transceiver once the device acknowledges. The bus acknowledge comes after that. The same input/output code can occur once on the way up and once on the way back down, so an internal phase bit is kept to tell the two apart. It is set when a cycle starts and cleared when the return phase begins.

The three asynchronous inputs pass through a multi-flop synchronizer, and every decision uses the synchronized copies. Protocol violations abort the cycle, bring all outputs low and set an error flag that only reset clears.

Top module: `hsb_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it, the local strobe, the transceiver enable, the bus acknowledge and the error flag are all low.
- R2: Every input passes through SYNC_STAGES flops. A strobe that rises in idle makes its first output rise SYNC_STAGES+1 clock edges later. A device acknowledge edge makes the output it enables move SYNC_STAGES+1 edges later.
- R3: In a read cycle, the local strobe rises first. Once the acknowledge is seen, the transceiver enable rises. The bus acknowledge rises exactly one clock after the transceiver enable.
- R4: In a read cycle, after the read strobe falls, the transceiver enable falls. On the next clock, the local strobe and the bus acknowledge fall on the same edge.
- R5: In a write cycle, the transceiver enable rises first and the local strobe rises one clock later. Once the acknowledge is seen, the transceiver enable falls. The bus acknowledge rises one clock after that.
- R6: In a write cycle, after the write strobe falls, the local strobe and the bus acknowledge fall on the same edge. The transceiver enable stays low.
- R7: The transceiver enable is already low on the clock before any fall of the local strobe.
- R8: No new cycle starts until the device acknowledge of the previous cycle is seen low. A read strobe raised while the acknowledge is still high leaves the local strobe low. Once the acknowledge falls, the local strobe rises SYNC_STAGES+2 edges later.
- R9: Both strobes seen high together in idle set the error flag. All outputs stay low.
- R10: A strobe that falls before the bus acknowledge has risen sets the error flag and drops every output on the same edge.
- R11: A device acknowledge that is high in idle, or that falls while the local strobe is still high, sets the error flag and drops every output.
- R12: Once set, the error flag stays high until reset, whatever the inputs do.
- R13: In a complete cycle, each of the three handshake outputs rises exactly once and falls exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Bus read strobe (asynchronous) |
| wr_req_i | input | 1 | Bus write strobe (asynchronous) |
| dev_ack_i | input | 1 | Device acknowledge (asynchronous) |
| dev_stb_o | output | 1 | Local strobe to the device |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge to the bus master |
| proto_err_o | output | 1 | Sticky protocol error flag |

## Verification
The bench builds the block with SYNC_STAGES = 2, the smallest depth allowed. With that depth every latency is short enough to be checked to the exact edge. The bench sweeps every pairing of device response delay and bus release delay from 0 to 3 clocks, for reads and for writes. This covers both the case where the acknowledge arrives in the first possible cycle and the case where the bus lingers. Each violation class is then forced on its own: both strobes together, an early strobe release, a stray acknowledge, and an early acknowledge release. A read re-raised while the acknowledge is still held shows the start gate at its edge.

// File: rtl/hsb_pkg.sv
`timescale 1ns/1ps
package hsb_pkg;

   // Controller states: read branch, write branch, shared return wait.
   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_R_WACK  = 4'd1,
      ST_R_XON   = 4'd2,
      ST_R_HOLD  = 4'd3,
      ST_R_DOWN  = 4'd4,
      ST_W_XON   = 4'd5,
      ST_W_WACK  = 4'd6,
      ST_W_XOFF  = 4'd7,
      ST_W_HOLD  = 4'd8,
      ST_RET     = 4'd9
   } hsb_state_e;

   // Bit positions of the synchronized input bundle.
   localparam int IN_RD  = 0;
   localparam int IN_WR  = 1;
   localparam int IN_ACK = 2;
   localparam int IN_W   = 3;

endpackage

// File: rtl/hsb_sync.sv
`timescale 1ns/1ps
module hsb_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int TOP = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("hsb_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hsb_sync: WIDTH must be at least 1");
      end
   endgenerate

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [TOP:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[TOP-1:0], d_i[b]};
         end
         assign q_o[b] = chain[TOP];
      end
   endgenerate

endmodule

// File: rtl/hsb_viol.sv
`timescale 1ns/1ps
module hsb_viol
   import hsb_pkg::*;
(
   input  hsb_state_e state_i,
   input  logic       rd_i,
   input  logic       wr_i,
   input  logic       ack_i,
   output logic       viol_o
);

   // Which input combinations are illegal in each state.
   always_comb begin
      unique case (state_i)
         ST_IDLE:   viol_o = (rd_i && wr_i) || ack_i;
         ST_R_WACK: viol_o = !rd_i || wr_i;
         ST_R_XON:  viol_o = !rd_i || wr_i || !ack_i;
         ST_R_HOLD: viol_o = wr_i || !ack_i;
         ST_R_DOWN: viol_o = wr_i || !ack_i;
         ST_W_XON:  viol_o = !wr_i || rd_i || ack_i;
         ST_W_WACK: viol_o = !wr_i || rd_i;
         ST_W_XOFF: viol_o = !wr_i || rd_i || !ack_i;
         ST_W_HOLD: viol_o = rd_i || !ack_i;
         ST_RET:    viol_o = 1'b0;
         default:   viol_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/hsb_seq.sv
`timescale 1ns/1ps
module hsb_seq
   import hsb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_i,
   input  logic       wr_i,
   input  logic       ack_i,
   input  logic       viol_i,
   output hsb_state_e state_o,
   output logic       dev_stb_o,
   output logic       xcvr_en_o,
   output logic       bus_ack_o,
   output logic       err_o
);

   hsb_state_e state;
   logic       phase_up;   // set on the way up, cleared on the return phase

   assign state_o = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase_up  <= 1'b0;
         dev_stb_o <= 1'b0;
         xcvr_en_o <= 1'b0;
         bus_ack_o <= 1'b0;
         err_o     <= 1'b0;
      end else if (viol_i) begin
         state     <= ST_IDLE;
         phase_up  <= 1'b0;
         dev_stb_o <= 1'b0;
         xcvr_en_o <= 1'b0;
         bus_ack_o <= 1'b0;
         err_o     <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (rd_i) begin
                  dev_stb_o <= 1'b1;
                  phase_up  <= 1'b1;
                  state     <= ST_R_WACK;
               end else if (wr_i) begin
                  xcvr_en_o <= 1'b1;
                  phase_up  <= 1'b1;
                  state     <= ST_W_XON;
               end
            end
            ST_R_WACK: begin
               if (ack_i) begin
                  xcvr_en_o <= 1'b1;
                  state     <= ST_R_XON;
               end
            end
            ST_R_XON: begin
               bus_ack_o <= 1'b1;
               state     <= ST_R_HOLD;
            end
            ST_R_HOLD: begin
               if (!rd_i) begin
                  xcvr_en_o <= 1'b0;
                  state     <= ST_R_DOWN;
               end
            end
            ST_R_DOWN: begin
               dev_stb_o <= 1'b0;
               bus_ack_o <= 1'b0;
               phase_up  <= 1'b0;
               state     <= ST_RET;
            end
            ST_W_XON: begin
               dev_stb_o <= 1'b1;
               state     <= ST_W_WACK;
            end
            ST_W_WACK: begin
               if (ack_i) begin
                  xcvr_en_o <= 1'b0;
                  state     <= ST_W_XOFF;
               end
            end
            ST_W_XOFF: begin
               bus_ack_o <= 1'b1;
               state     <= ST_W_HOLD;
            end
            ST_W_HOLD: begin
               if (!wr_i) begin
                  dev_stb_o <= 1'b0;
                  bus_ack_o <= 1'b0;
                  phase_up  <= 1'b0;
                  state     <= ST_RET;
               end
            end
            ST_RET: begin
               if (!ack_i) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7: transceiver already off on the clock before the local strobe drops
   a_r7_xcvr_off_first: assert property (@(posedge clk) disable iff (!rst_n || err_o)
      $fell(dev_stb_o) |-> !$past(xcvr_en_o));

   // R3: bus acknowledge only rises inside an established local strobe
   a_r3_ack_inside_stb: assert property (@(posedge clk) disable iff (!rst_n || err_o)
      $rose(bus_ack_o) |-> (dev_stb_o && $past(dev_stb_o)));

   // R8: a cycle only starts while the device acknowledge is seen low
   a_r8_start_ack_low: assert property (@(posedge clk) disable iff (!rst_n || err_o)
      $rose(phase_up) |-> !$past(ack_i));

   // R13: no output moves on two consecutive edges
   a_r13_stb_once: assert property (@(posedge clk) disable iff (!rst_n || err_o)
      !$stable(dev_stb_o) |=> $stable(dev_stb_o));
   a_r13_xcvr_once: assert property (@(posedge clk) disable iff (!rst_n || err_o)
      !$stable(xcvr_en_o) |=> $stable(xcvr_en_o));
   a_r13_ack_once: assert property (@(posedge clk) disable iff (!rst_n || err_o)
      !$stable(bus_ack_o) |=> $stable(bus_ack_o));

   // R12: the error flag never clears without reset
   a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

endmodule

// File: rtl/hsb_ctrl.sv
`timescale 1ns/1ps
module hsb_ctrl
   import hsb_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req_i,
   input  logic wr_req_i,
   input  logic dev_ack_i,
   output logic dev_stb_o,
   output logic xcvr_en_o,
   output logic bus_ack_o,
   output logic proto_err_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hsb_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [IN_W-1:0] raw_in;
   logic [IN_W-1:0] syn_in;
   hsb_state_e      state;
   logic            viol;

   assign raw_in[IN_RD]  = rd_req_i;
   assign raw_in[IN_WR]  = wr_req_i;
   assign raw_in[IN_ACK] = dev_ack_i;

   hsb_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (IN_W)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   hsb_viol u_viol (
      .state_i (state),
      .rd_i    (syn_in[IN_RD]),
      .wr_i    (syn_in[IN_WR]),
      .ack_i   (syn_in[IN_ACK]),
      .viol_o  (viol)
   );

   hsb_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_i      (syn_in[IN_RD]),
      .wr_i      (syn_in[IN_WR]),
      .ack_i     (syn_in[IN_ACK]),
      .viol_i    (viol),
      .state_o   (state),
      .dev_stb_o (dev_stb_o),
      .xcvr_en_o (xcvr_en_o),
      .bus_ack_o (bus_ack_o),
      .err_o     (proto_err_o)
   );

   // R1: outputs quiet on the clock following any reset cycle
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!dev_stb_o && !xcvr_en_o && !bus_ack_o && !proto_err_o));

   // R10: an error drops every handshake output on the same edge
   a_r10_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(proto_err_o) |-> (!dev_stb_o && !xcvr_en_o && !bus_ack_o));

endmodule

// File: tb/hsb_ctrl_tb.sv
`timescale 1ns/1ps
module hsb_ctrl_tb;

   localparam int S = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
   logic dev_stb, xcvr_en, bus_ack, perr;

   int total = 0;
   int fails = 0;
   int tgl [3];
   logic [2:0] prev_o = 3'b000;

   always #5 clk = ~clk;

   hsb_ctrl #(.SYNC_STAGES(S)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_req_i(rd), .wr_req_i(wr), .dev_ack_i(ack),
      .dev_stb_o(dev_stb), .xcvr_en_o(xcvr_en), .bus_ack_o(bus_ack), .proto_err_o(perr)
   );

   wire logic [3:0] outs = {perr, bus_ack, xcvr_en, dev_stb};

   initial begin
      for (int i = 0; i < 3; i++) tgl[i] = 0;
   end

   // toggle monitor for the three handshake outputs
   always @(negedge clk) begin
      for (int i = 0; i < 3; i++) if (outs[i] !== prev_o[i]) tgl[i] = tgl[i] + 1;
      prev_o = outs[2:0];
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   task automatic wait_for(input int idx, input logic val, output int n);
      n = 0;
      while (outs[idx] !== val && n < 100) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rd = 1'b0; wr = 1'b0; ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_read(input int dd, input int db);
      int n;
      int t0 [3];
      for (int i = 0; i < 3; i++) t0[i] = tgl[i];
      rd = 1'b1;
      wait_for(0, 1'b1, n);
      chk("R2 read strobe to local strobe latency", n, S + 1);
      chk("R3 transceiver low at local strobe rise", xcvr_en, 0);
      repeat (dd) @(negedge clk);
      ack = 1'b1;
      wait_for(1, 1'b1, n);
      chk("R2 ack to transceiver latency", n, S + 1);
      chk("R3 bus ack low at transceiver rise", bus_ack, 0);
      wait_for(2, 1'b1, n);
      chk("R3 bus ack one clock after transceiver", n, 1);
      repeat (db) @(negedge clk);
      rd = 1'b0;
      wait_for(1, 1'b0, n);
      chk("R4 strobe release to transceiver fall", n, S + 1);
      chk("R7 local strobe still high at transceiver fall", dev_stb, 1);
      @(negedge clk);
      chk("R4 local strobe and bus ack fall together", {dev_stb, bus_ack}, 0);
      repeat (dd) @(negedge clk);
      ack = 1'b0;
      repeat (S + 1) @(negedge clk);
      #1;
      for (int i = 0; i < 3; i++) chk("R13 read toggles per output", tgl[i] - t0[i], 2);
   endtask

   task automatic run_write(input int dd, input int db);
      int n;
      int t0 [3];
      for (int i = 0; i < 3; i++) t0[i] = tgl[i];
      wr = 1'b1;
      wait_for(1, 1'b1, n);
      chk("R5 write strobe to transceiver latency", n, S + 1);
      chk("R5 local strobe low at transceiver rise", dev_stb, 0);
      wait_for(0, 1'b1, n);
      chk("R5 local strobe one clock after transceiver", n, 1);
      repeat (dd) @(negedge clk);
      ack = 1'b1;
      wait_for(1, 1'b0, n);
      chk("R5 ack to transceiver fall", n, S + 1);
      wait_for(2, 1'b1, n);
      chk("R5 bus ack one clock after transceiver fall", n, 1);
      repeat (db) @(negedge clk);
      wr = 1'b0;
      wait_for(0, 1'b0, n);
      chk("R6 strobe release to local strobe fall", n, S + 1);
      chk("R6 bus ack falls with local strobe", bus_ack, 0);
      chk("R7 transceiver low at local strobe fall", xcvr_en, 0);
      repeat (dd) @(negedge clk);
      ack = 1'b0;
      repeat (S + 1) @(negedge clk);
      #1;
      for (int i = 0; i < 3; i++) chk("R13 write toggles per output", tgl[i] - t0[i], 2);
   endtask

   initial begin : main
      int n;
      int early;
      repeat (3) @(negedge clk);
      chk("R1 outputs low in reset", int'(outs), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs low after reset", int'(outs), 0);

      // timing sweep, reads and writes interleaved back to back
      for (int dd = 0; dd < 4; dd++) begin
         for (int db = 0; db < 4; db++) begin
            run_read(dd, db);
            run_write(dd, db);
         end
      end
      chk("R12 no error over legal traffic", perr, 0);

      // R8: read raised again while acknowledge still held
      rd = 1'b1;
      wait_for(0, 1'b1, n);
      ack = 1'b1;
      wait_for(2, 1'b1, n);
      rd = 1'b0;
      wait_for(0, 1'b0, n);
      rd = 1'b1;
      early = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (dev_stb) early++;
      end
      chk("R8 no restart while ack held", early, 0);
      ack = 1'b0;
      wait_for(0, 1'b1, n);
      chk("R8 restart latency after ack fall", n, S + 2);
      do_reset();

      // R9: both strobes in idle
      rd = 1'b1; wr = 1'b1;
      wait_for(3, 1'b1, n);
      chk("R9 both strobes error latency", n, S + 1);
      chk("R9 outputs low", int'(outs[2:0]), 0);
      do_reset();
      chk("R1 error cleared by reset", perr, 0);

      // R10: read strobe drops before bus ack
      rd = 1'b1;
      wait_for(0, 1'b1, n);
      rd = 1'b0;
      wait_for(3, 1'b1, n);
      chk("R10 early release error latency", n, S + 1);
      chk("R10 outputs dropped", int'(outs[2:0]), 0);
      do_reset();

      // R11: stray acknowledge in idle
      ack = 1'b1;
      wait_for(3, 1'b1, n);
      chk("R11 stray ack error latency", n, S + 1);
      chk("R11 outputs low on stray ack", int'(outs[2:0]), 0);
      do_reset();

      // R11: acknowledge released while the local strobe is held (write)
      wr = 1'b1;
      wait_for(0, 1'b1, n);
      ack = 1'b1;
      wait_for(2, 1'b1, n);
      ack = 1'b0;
      wait_for(3, 1'b1, n);
      chk("R11 early ack release error latency", n, S + 1);
      chk("R11 outputs dropped on early ack release", int'(outs[2:0]), 0);

      // R12: flag holds with inputs quiet
      wr = 1'b0;
      repeat (10) @(negedge clk);
      chk("R12 error flag sticky", perr, 1);
      do_reset();
      chk("R12 error flag cleared only by reset", perr, 0);

      report();
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
   end

endmodule